// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

A synthesizable behavioural model of a 32-bit-wide synchronous static RAM. The RAM holds a short burst sequencer and a pipelined read register. Every control and data input is sampled on the rising clock edge. An address is captured when one of two start strobes is low. The processor-side strobe always begins a read. The controller-side strobe begins a read or a write, chosen by the write enables sampled on the same edge. While neither strobe is low, a low step input advances a 2-bit beat counter. The counter walks the two low address bits in either linear (wrap-around add) or interleaved (XOR) order, and the upper address bits stay fixed.

Writes happen on the edge that carries them. They can cover any subset of the four byte lanes, or all lanes through a global write input. Read data reaches the output register one edge after the address is registered. The output is qualified by a drive flag, which stands for the pad's high-impedance state. The flag drops at once, with no clock, when the output-enable input is high or the sleep input is high. While sleep is high, the RAM ignores every clock edge. Array depth is set by `ADDR_W`: the default of 10 suits simulation, and `ADDR_W = 17` gives the full 131,072-word organisation. The synchronous reset clears the select, read-pending and drive state. The array contents are not cleared.

Top module: `burst_sram`

## Requirements
- R1: After reset, `dq_drive` is 0.
- R2: An edge with `proc_start_n` = 0 and `sel_a_n` = 0 is a read even if write enables are active. After the next edge, `dq_out` holds the word at the loaded address and `dq_drive` is 1, provided the chip is selected, `out_en_n` = 0 and `sleep` = 0.
- R3: An edge with `proc_start_n` = 0, `sel_a_n` = 1 and `ctrl_start_n` = 1 is ignored. It writes nothing, and `dq_drive` is 0 after the next edge.
- R4: On a write edge with `all_lanes_n` = 1 and `lane_gate_n` = 0, byte lane i (bits 8i+7:8i) is written only when `lane_n[i]` = 0. The other lanes keep their contents.
- R5: `all_lanes_n` = 0 writes all four lanes, whatever `lane_gate_n` and `lane_n` are.
- R6: With `order_ilv` = 0, beat k of a burst that starts at address S uses the low bits (S[1:0] + k) mod 4, and the upper bits stay S's.
- R7: With `order_ilv` = 1, beat k uses the low bits S[1:0] XOR k.
- R8: An edge with both strobes high and `step_n` = 1 keeps the address. A selected burst then re-reads the same word.
- R9: A load is selected only when `sel_a_n` = 0, `sel_b` = 1 and `sel_c_n` = 0. A deselected load writes nothing and leaves `dq_drive` at 0.
- R10: `out_en_n` = 1 forces `dq_drive` to 0 without a clock edge. Returning it to 0 restores the driven data.
- R11: `sleep` = 1 forces `dq_drive` to 0 without a clock edge, and any write presented while asleep is lost.
- R12: A read loaded on the edge right after a write to the same address returns the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr_in | input | ADDR_W | Word address |
| wdata | input | 32 | Write data |
| dq_out | output | 32 | Registered read data |
| dq_drive | output | 1 | Output driven (0 means high impedance) |
| sel_a_n | input | 1 | Select, active low (qualifies the processor strobe) |
| sel_b | input | 1 | Depth-expansion select, active high |
| sel_c_n | input | 1 | Depth-expansion select, active low |
| proc_start_n | input | 1 | Processor start strobe, active low (read) |
| ctrl_start_n | input | 1 | Controller start strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| order_ilv | input | 1 | 1 selects interleaved order, 0 selects linear order |
| lane_n | input | 4 | Per-lane write enables, active low |
| lane_gate_n | input | 1 | Enables the per-lane writes, active low |
| all_lanes_n | input | 1 | Global write of all lanes, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous sleep, active high |

## Verification
The hardest situations to reach are the edges where a write enable is present but must not take effect. These are a processor-strobe read with global write low, a processor strobe ignored because `sel_a_n` is high, a deselected controller load, and a write presented during sleep. In each case, the bench first fills the whole small array with address-derived words. It then applies the blocked write with a distinctive pattern and re-reads the target address. The re-read shows whether any lane was touched. Burst order is swept over every start address in both orders, so the wrap of the low bits and the fixed upper bits are checked for all 64 words.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int DATA_W = LANES * LANE_W;

  // low address bits of beat k of a burst that starts at start
  function automatic logic [1:0] beat_lo(input logic [1:0] start,
                                         input logic [1:0] k,
                                         input logic ilv);
    return ilv ? (start ^ k) : (start + k);
  endfunction
endpackage

// File: rtl/burst_seq.sv
module burst_seq #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              load,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              step,
  input  logic              ilv,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-1:0] nxt_addr
);
  import burst_sram_pkg::*;

  logic [ADDR_W-3:0] base_q;
  logic [1:0]        start_q;
  logic [1:0]        cnt_q;
  logic [1:0]        cnt_nx;

  assign cnt_nx = cnt_q + 2'd1;

  always_comb begin
    if (load)      nxt_addr = ld_addr;
    else if (step) nxt_addr = {base_q, beat_lo(start_q, cnt_nx, ilv)};
    else           nxt_addr = cur_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q   <= '0;
      start_q  <= '0;
      cnt_q    <= '0;
      cur_addr <= '0;
    end else if (en) begin
      if (load) begin
        base_q  <= ld_addr[ADDR_W-1:2];
        start_q <= ld_addr[1:0];
        cnt_q   <= '0;
      end else if (step) begin
        cnt_q <= cnt_nx;
      end
      cur_addr <= nxt_addr;
    end
  end
endmodule

// File: rtl/lane_we_dec.sv
module lane_we_dec #(
  parameter int LANES = 4
) (
  input  logic             permit,
  input  logic             all_n,
  input  logic             gate_n,
  input  logic [LANES-1:0] lane_n,
  output logic [LANES-1:0] we
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign we[i] = permit & (~all_n | (~gate_n & ~lane_n[i]));
  end
endmodule

// File: rtl/byte_lane_ram.sv
module byte_lane_ram #(
  parameter int ADDR_W = 10,
  parameter int W      = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [W-1:0]      wd,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [W-1:0]      rd_q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [W-1:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wd;
  end

  always_ff @(posedge clk) begin
    if (re) rd_q <= mem[raddr];
  end
endmodule

// File: rtl/burst_sram.sv
module burst_sram #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [31:0]       wdata,
  output logic [31:0]       dq_out,
  output logic              dq_drive,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              proc_start_n,
  input  logic              ctrl_start_n,
  input  logic              step_n,
  input  logic              order_ilv,
  input  logic [3:0]        lane_n,
  input  logic              lane_gate_n,
  input  logic              all_lanes_n,
  input  logic              out_en_n,
  input  logic              sleep
);
  import burst_sram_pkg::*;

  logic              awake;
  logic              sel_ok;
  logic              p_take, c_take, cont, load;
  logic              access, permit_w, any_we, step;
  logic              sel_q, rd_q, drv_q;
  logic [LANES-1:0]  we;
  logic [ADDR_W-1:0] cur_addr, nxt_addr;

  assign awake  = ~sleep;
  assign sel_ok = ~sel_a_n & sel_b & ~sel_c_n;
  assign p_take = ~proc_start_n & ~sel_a_n;
  assign c_take = ~p_take & ~ctrl_start_n;
  assign cont   = proc_start_n & ctrl_start_n;
  assign load   = p_take | c_take;
  assign access = load ? sel_ok : (cont & sel_q);
  assign permit_w = awake & access & ~p_take & ~rst;
  assign step   = cont & ~step_n & sel_q;
  assign any_we = |we;

  burst_seq #(.ADDR_W(ADDR_W)) seq_i (
    .clk(clk), .rst(rst), .en(awake), .load(load), .ld_addr(addr_in),
    .step(step), .ilv(order_ilv), .cur_addr(cur_addr), .nxt_addr(nxt_addr)
  );

  lane_we_dec #(.LANES(LANES)) dec_i (
    .permit(permit_w), .all_n(all_lanes_n), .gate_n(lane_gate_n),
    .lane_n(lane_n), .we(we)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_ram
    byte_lane_ram #(.ADDR_W(ADDR_W), .W(LANE_W)) ram_i (
      .clk(clk), .we(we[i]), .waddr(nxt_addr),
      .wd(wdata[i*LANE_W +: LANE_W]),
      .re(awake & rd_q), .raddr(cur_addr),
      .rd_q(dq_out[i*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= 1'b0;
      rd_q  <= 1'b0;
      drv_q <= 1'b0;
    end else if (awake) begin
      drv_q <= rd_q;
      if (load) sel_q <= sel_ok;
      rd_q <= access & ~any_we;
    end
  end

  assign dq_drive = drv_q & ~out_en_n & ~sleep;
endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk (
  input logic       clk,
  input logic       rst,
  input logic       dq_drive,
  input logic       sel_a_n,
  input logic       sel_b,
  input logic       sel_c_n,
  input logic       proc_start_n,
  input logic       ctrl_start_n,
  input logic       out_en_n,
  input logic       sleep
);
  p_float_oe_r10: assert property (@(posedge clk) disable iff (rst)
    out_en_n |-> !dq_drive);

  p_float_sleep_r11: assert property (@(posedge clk) disable iff (rst)
    sleep |-> !dq_drive);

  p_ignored_start_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(!proc_start_n && sel_a_n && ctrl_start_n && !sleep, 2) &&
     $past(!sleep, 1)) |-> !dq_drive);

  p_deselect_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(proc_start_n && !ctrl_start_n && (sel_a_n || !sel_b || sel_c_n) && !sleep, 2) &&
     $past(!sleep, 1)) |-> !dq_drive);

  p_read_drives_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst, 2) && $past(!rst, 1) &&
     $past(!proc_start_n && !sel_a_n && sel_b && !sel_c_n && !sleep, 2) &&
     $past(!sleep, 1) && !out_en_n && !sleep) |-> dq_drive);
endmodule

bind burst_sram burst_sram_chk chk_i (.*);

// File: tb/burst_sram_tb_top.sv
`timescale 1ns/1ps
module burst_sram_tb_top;
  localparam int AW = 6;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr_in = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   dq_out;
  logic          dq_drive;
  logic          sel_a_n = 1'b0, sel_b = 1'b1, sel_c_n = 1'b0;
  logic          proc_start_n = 1'b1, ctrl_start_n = 1'b1, step_n = 1'b1;
  logic          order_ilv = 1'b0;
  logic [3:0]    lane_n = 4'hF;
  logic          lane_gate_n = 1'b1, all_lanes_n = 1'b1;
  logic          out_en_n = 1'b0, sleep = 1'b0;

  int n_chk = 0, n_bad = 0;
  bit timeout = 1'b0;
  logic [31:0] exp_mem [0:N-1];

  always #2.5 clk = ~clk;

  burst_sram #(.ADDR_W(AW)) dut_i (.*);

  function automatic logic [31:0] pat(input int a);
    return (32'(a) * 32'h0103_0507) ^ 32'hA500_0000;
  endfunction

  function automatic int beat_addr(input int s, input int k, input bit ilv);
    return (s & ~3) | ((ilv ? (s ^ k) : (s + k)) & 3);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic idle();
    proc_start_n = 1'b1; ctrl_start_n = 1'b1; step_n = 1'b1;
    all_lanes_n = 1'b1; lane_gate_n = 1'b1; lane_n = 4'hF;
    sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0;
  endtask

  // R5 R6: linear write burst of four words from base with global write
  task automatic wr_burst(input int base);
    @(negedge clk);
    ctrl_start_n = 1'b0; addr_in = AW'(base); all_lanes_n = 1'b0; wdata = pat(base);
    exp_mem[base] = pat(base);
    for (int k = 1; k < 4; k++) begin
      @(posedge clk); @(negedge clk);
      ctrl_start_n = 1'b1; step_n = 1'b0;
      wdata = pat(beat_addr(base, k, 1'b0));
      exp_mem[beat_addr(base, k, 1'b0)] = pat(beat_addr(base, k, 1'b0));
    end
    @(posedge clk); @(negedge clk);
    idle();
  endtask

  task automatic wr_one(input int a, input logic [31:0] d, input logic all_n,
                        input logic gate_n, input logic [3:0] ln);
    @(negedge clk);
    ctrl_start_n = 1'b0; addr_in = AW'(a); wdata = d;
    all_lanes_n = all_n; lane_gate_n = gate_n; lane_n = ln;
    for (int i = 0; i < 4; i++)
      if (!all_n || (!gate_n && !ln[i])) exp_mem[a][i*8 +: 8] = d[i*8 +: 8];
    @(posedge clk); @(negedge clk);
    idle();
  endtask

  // R2: single read, checked one edge after the load
  task automatic rd_one(input int a, input string req);
    @(negedge clk);
    proc_start_n = 1'b0; addr_in = AW'(a);
    @(posedge clk); @(negedge clk);
    idle();
    @(posedge clk); @(negedge clk);
    check(dq_drive === 1'b1 && dq_out === exp_mem[a], req, dq_out, exp_mem[a]);
  endtask

  task automatic rd_burst(input int s, input bit ilv, input string req);
    @(negedge clk);
    order_ilv = ilv; proc_start_n = 1'b0; addr_in = AW'(s);
    @(posedge clk); @(negedge clk);
    proc_start_n = 1'b1; step_n = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); @(negedge clk);
      check(dq_drive === 1'b1 && dq_out === exp_mem[beat_addr(s, k, ilv)], req,
            dq_out, exp_mem[beat_addr(s, k, ilv)]);
      if (k == 2) step_n = 1'b1;
    end
    idle();
  endtask

  task automatic run_all();
    logic [31:0] mark;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    check(dq_drive === 1'b0, "R1 reset drive", {31'b0, dq_drive}, 32'h0);

    for (int b = 0; b < N; b += 4) wr_burst(b);
    for (int s = 0; s < N; s++) rd_burst(s, 1'b0, "R6 R2 linear burst");
    for (int s = 0; s < N; s++) rd_burst(s, 1'b1, "R7 interleaved burst");

    // R4: every lane mask
    for (int m = 0; m < 16; m++) begin
      wr_one(m + 8, 32'h5A00_0000 + 32'(m * 16'h0111), 1'b1, 1'b0, ~4'(m));
      rd_one(m + 8, "R4 lane mask");
    end
    // R5: global write overrides lane inputs
    wr_one(30, 32'hC0FF_EE11, 1'b0, 1'b1, 4'hF);
    rd_one(30, "R5 global write");

    // R2: processor strobe with global write active does not write
    @(negedge clk);
    proc_start_n = 1'b0; addr_in = AW'(33); all_lanes_n = 1'b0; wdata = 32'hDEAD_0001;
    @(posedge clk); @(negedge clk);
    idle();
    @(posedge clk); @(negedge clk);
    check(dq_drive === 1'b1 && dq_out === exp_mem[33], "R2 no write on read strobe",
          dq_out, exp_mem[33]);

    // R3: ignored processor strobe
    @(negedge clk);
    proc_start_n = 1'b0; sel_a_n = 1'b1; addr_in = AW'(40); all_lanes_n = 1'b0;
    wdata = 32'hDEAD_0002;
    @(posedge clk); @(negedge clk);
    idle();
    @(posedge clk); @(negedge clk);
    check(dq_drive === 1'b0, "R3 ignored start drive", {31'b0, dq_drive}, 32'h0);
    rd_one(40, "R3 ignored start no write");

    // R9: deselected controller load with write
    for (int v = 0; v < 3; v++) begin
      @(negedge clk);
      ctrl_start_n = 1'b0; addr_in = AW'(41 + v); all_lanes_n = 1'b0; wdata = 32'hDEAD_0003;
      sel_b = (v != 0); sel_a_n = (v == 1); sel_c_n = (v == 2);
      @(posedge clk); @(negedge clk);
      idle(); sel_b = 1'b0;
      @(posedge clk); @(negedge clk);
      check(dq_drive === 1'b0, "R9 deselect drive", {31'b0, dq_drive}, 32'h0);
      idle();
      rd_one(41 + v, "R9 deselect no write");
    end

    // R10: asynchronous output enable
    rd_one(12, "R2 read before oe");
    out_en_n = 1'b1; #1;
    check(dq_drive === 1'b0, "R10 oe float", {31'b0, dq_drive}, 32'h0);
    out_en_n = 1'b0; #1;
    check(dq_drive === 1'b1 && dq_out === exp_mem[12], "R10 oe restore", dq_out, exp_mem[12]);

    // R11: sleep floats output and drops writes
    @(negedge clk);
    sleep = 1'b1; #1;
    check(dq_drive === 1'b0, "R11 sleep float", {31'b0, dq_drive}, 32'h0);
    ctrl_start_n = 1'b0; addr_in = AW'(50); all_lanes_n = 1'b0; wdata = 32'hDEAD_0004;
    @(posedge clk); @(negedge clk);
    idle(); sleep = 1'b0;
    rd_one(50, "R11 sleep no write");

    // R8: hold address without step
    @(negedge clk);
    proc_start_n = 1'b0; addr_in = AW'(21); order_ilv = 1'b0;
    @(posedge clk); @(negedge clk);
    idle();
    @(posedge clk); @(negedge clk);
    check(dq_out === exp_mem[21], "R8 hold beat a", dq_out, exp_mem[21]);
    @(posedge clk); @(negedge clk);
    check(dq_out === exp_mem[21], "R8 hold repeat", dq_out, exp_mem[21]);
    step_n = 1'b0;
    @(posedge clk); @(negedge clk);
    step_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check(dq_out === exp_mem[22], "R8 step after hold", dq_out, exp_mem[22]);

    // R12: read right after write to the same address
    mark = 32'h1234_ABCD;
    @(negedge clk);
    ctrl_start_n = 1'b0; addr_in = AW'(60); all_lanes_n = 1'b0; wdata = mark;
    exp_mem[60] = mark;
    @(posedge clk); @(negedge clk);
    idle(); proc_start_n = 1'b0; addr_in = AW'(60);
    @(posedge clk); @(negedge clk);
    idle();
    @(posedge clk); @(negedge clk);
    check(dq_drive === 1'b1 && dq_out === mark, "R12 write then read", dq_out, mark);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        timeout = 1'b1;
      end
    join_any
    if (timeout) check(1'b0, "watchdog", 32'h0, 32'h1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule